// File: doc/BRIEF.md
# Two-Mode Wrapping Burst Address Counter

This block produces the low address bits for a fixed-length burst to a synchronous memory. When a burst begins, a load strobe captures the starting low bits and the selected ordering. After that, each cycle in which the active-low advance input is driven low moves the output to the next position of the burst. The count wraps inside the aligned group and never carries into the upper address bits.

Two orderings are supported. Linear order adds the beat index to the start value, modulo the burst length. Interleaved order combines the start value and the beat index with XOR, which is the sequence that some cache-line fill protocols expect. The burst length is a power of two set by a parameter. The default of two bits gives four-beat bursts.

Top module: `burst_wrap_ctr`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `addr_lo` = 0 and `beat_idx` = 0.
- R2: In the cycle after a rising edge with `burst_load` = 1, `addr_lo` equals the `start_lo` sampled at that edge and `beat_idx` = 0.
- R3: At a rising edge with `burst_load` = 0 and `adv_n` = 0, `beat_idx` increments by one, modulo 2^BURST_BITS.
- R4: At a rising edge with `burst_load` = 0 and `adv_n` = 1, both `addr_lo` and `beat_idx` keep their values.
- R5: When `burst_load` = 1 and `adv_n` = 0 at the same edge, the load wins. The outputs show the new start value and beat 0.
- R6: With linear order (`order_sel` = 0 at load), `addr_lo` = (start + `beat_idx`) mod 2^BURST_BITS. From a start of 01 the four-beat sequence is 01,10,11,00.
- R7: With interleaved order (`order_sel` = 1 at load), `addr_lo` = start XOR `beat_idx`. From a start of 01 the sequence is 01,00,11,10, and from 10 it is 10,11,00,01.
- R8: `order_sel` is sampled only at a load. Changing it between loads does not alter `addr_lo`.
- R9: An advance taken at the last beat returns `beat_idx` to 0 and `addr_lo` to the start value. No flag is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| burst_load | input | 1 | Starts a burst; captures `start_lo` and `order_sel` |
| start_lo | input | BURST_BITS | Low address bits of the first beat |
| adv_n | input | 1 | Advance to the next beat when low |
| order_sel | input | 1 | 0 selects linear order, 1 selects interleaved order |
| addr_lo | output | BURST_BITS | Current low address bits |
| beat_idx | output | BURST_BITS | Number of beats advanced since the load, modulo the burst length |

## Verification
The bench builds the block with the default BURST_BITS = 2. At that size the whole input space is small: four start values, two orderings and four beat positions. The vector table therefore covers every start value in both modes, including the wrap back to the start. It also covers the mode flip in the middle of a burst and the cycles in which the advance input is held high.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int DEFAULT_BURST_BITS = 2;

    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } order_e;

endpackage

// File: rtl/burst_seed_reg.sv
module burst_seed_reg
    import burst_pkg::*;
#(
    parameter int BURST_BITS = DEFAULT_BURST_BITS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [BURST_BITS-1:0] start_in,
    input  order_e                order_in,
    output logic [BURST_BITS-1:0] start_q,
    output order_e                order_q
);

    typedef struct packed {
        order_e                order;
        logic [BURST_BITS-1:0] start;
    } seed_t;

    seed_t seed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seed_q <= '{order: ORDER_LINEAR, start: '0};
        end else if (load) begin
            seed_q <= '{order: order_in, start: start_in};
        end
    end

    assign start_q = seed_q.start;
    assign order_q = seed_q.order;

    // R8: the captured ordering only changes at a load
    a_r8_order_held : assert property (@(posedge clk) disable iff (rst)
        !load |=> order_q == $past(order_q));

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
    parameter int BURST_BITS = burst_pkg::DEFAULT_BURST_BITS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  adv_n,
    output logic [BURST_BITS-1:0] beat_q
);

    localparam logic [BURST_BITS-1:0] LAST_BEAT = {BURST_BITS{1'b1}};

    logic [BURST_BITS-1:0] beat_d;

    always_comb begin
        beat_d = beat_q;
        if (load) begin
            beat_d = '0;
        end else if (!adv_n) begin
            beat_d = beat_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_d;
        end
    end

    a_r3_adv_steps : assert property (@(posedge clk) disable iff (rst)
        (!load && !adv_n && beat_q != LAST_BEAT) |=> beat_q == $past(beat_q) + 1'b1);

    a_r9_wrap_to_zero : assert property (@(posedge clk) disable iff (rst)
        (!load && !adv_n && beat_q == LAST_BEAT) |=> beat_q == '0);

    a_r5_load_clears : assert property (@(posedge clk) disable iff (rst)
        load |=> beat_q == '0);

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
    import burst_pkg::*;
#(
    parameter int BURST_BITS = DEFAULT_BURST_BITS
) (
    input  logic [BURST_BITS-1:0] start,
    input  order_e                order,
    input  logic [BURST_BITS-1:0] beat,
    output logic [BURST_BITS-1:0] addr
);

    logic [BURST_BITS-1:0] lin_addr;
    logic [BURST_BITS-1:0] xor_addr;

    // Sum truncated to BURST_BITS: the carry out is dropped, so the
    // address wraps within the aligned group.
    assign lin_addr = start + beat;

    for (genvar b = 0; b < BURST_BITS; b++) begin : g_xor_bit
        assign xor_addr[b] = start[b] ^ beat[b];
    end

    always_comb begin
        unique case (order)
            ORDER_XOR:    addr = xor_addr;
            default:      addr = lin_addr;
        endcase
    end

endmodule

// File: rtl/burst_wrap_ctr.sv
module burst_wrap_ctr
    import burst_pkg::*;
#(
    parameter int BURST_BITS = DEFAULT_BURST_BITS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  burst_load,
    input  logic [BURST_BITS-1:0] start_lo,
    input  logic                  adv_n,
    input  logic                  order_sel,
    output logic [BURST_BITS-1:0] addr_lo,
    output logic [BURST_BITS-1:0] beat_idx
);

    logic [BURST_BITS-1:0] start_q;
    order_e                order_q;

    burst_seed_reg #(.BURST_BITS(BURST_BITS)) u_seed (
        .clk      (clk),
        .rst      (rst),
        .load     (burst_load),
        .start_in (start_lo),
        .order_in (order_e'(order_sel)),
        .start_q  (start_q),
        .order_q  (order_q)
    );

    burst_beat_ctr #(.BURST_BITS(BURST_BITS)) u_beat (
        .clk    (clk),
        .rst    (rst),
        .load   (burst_load),
        .adv_n  (adv_n),
        .beat_q (beat_idx)
    );

    burst_addr_map #(.BURST_BITS(BURST_BITS)) u_map (
        .start (start_q),
        .order (order_q),
        .beat  (beat_idx),
        .addr  (addr_lo)
    );

    a_r2_start_on_load : assert property (@(posedge clk) disable iff (rst)
        burst_load |=> (addr_lo == $past(start_lo) && beat_idx == '0));

    a_r4_hold_when_idle : assert property (@(posedge clk) disable iff (rst)
        (!burst_load && adv_n) |=> ($stable(addr_lo) && $stable(beat_idx)));

    a_r1_reset_state : assert property (@(posedge clk)
        rst |=> (addr_lo == '0 && beat_idx == '0));

endmodule

// File: tb/sim_burst_wrap_ctr.sv
module sim_burst_wrap_ctr;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       burst_load = 1'b0;
    logic [1:0] start_lo = '0;
    logic       adv_n = 1'b1;
    logic       order_sel = 1'b0;
    logic [1:0] addr_lo;
    logic [1:0] beat_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    burst_wrap_ctr #(.BURST_BITS(2)) u0 (
        .clk        (clk),
        .rst        (rst),
        .burst_load (burst_load),
        .start_lo   (start_lo),
        .adv_n      (adv_n),
        .order_sel  (order_sel),
        .addr_lo    (addr_lo),
        .beat_idx   (beat_idx)
    );

    // {order, start, beat0, beat1, beat2, beat3}
    localparam logic [10:0] VEC [8] = '{
        {1'b0, 2'd0, 8'b00_01_10_11},
        {1'b0, 2'd1, 8'b01_10_11_00},
        {1'b0, 2'd2, 8'b10_11_00_01},
        {1'b0, 2'd3, 8'b11_00_01_10},
        {1'b1, 2'd0, 8'b00_01_10_11},
        {1'b1, 2'd1, 8'b01_00_11_10},
        {1'b1, 2'd2, 8'b10_11_00_01},
        {1'b1, 2'd3, 8'b11_10_01_00}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [1:0] a_exp, input logic [1:0] b_exp);
        n_checks++;
        if (addr_lo !== a_exp || beat_idx !== b_exp) begin
            n_fail++;
            $display("FAIL %s: addr_lo=%b beat_idx=%0d expected addr_lo=%b beat_idx=%0d",
                     req, addr_lo, beat_idx, a_exp, b_exp);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        tick();
        tick();
        check("R1 reset", 2'b00, 2'd0);
        rst = 1'b0;
        tick();
        check("R1 after reset release", 2'b00, 2'd0);

        for (int v = 0; v < 8; v++) begin
            logic       mode;
            logic [1:0] st;
            logic [7:0] seq;
            {mode, st, seq} = VEC[v];
            // R5: load and advance requested together, load must win
            order_sel  = mode;
            start_lo   = st;
            burst_load = 1'b1;
            adv_n      = 1'b0;
            tick();
            check(mode ? "R2 R5 R7 load" : "R2 R5 R6 load", seq[7:6], 2'd0);
            burst_load = 1'b0;
            // R8: flip the ordering input mid-burst, must have no effect
            order_sel  = ~mode;
            start_lo   = ~st;
            for (int k = 1; k < 4; k++) begin
                adv_n = 1'b0;
                tick();
                check(mode ? "R3 R7 R8 advance" : "R3 R6 R8 advance",
                      seq[7-2*k -: 2], 2'(k));
            end
            // R4: advance held high, outputs hold
            adv_n = 1'b1;
            tick();
            check("R4 hold", seq[1:0], 2'd3);
            tick();
            check("R4 hold second cycle", seq[1:0], 2'd3);
            // R9: wrap back to the start
            adv_n = 1'b0;
            tick();
            check("R9 wrap", st, 2'd0);
            adv_n = 1'b1;
        end

        // R1: reset in the middle of a burst
        burst_load = 1'b1;
        order_sel  = 1'b1;
        start_lo   = 2'd3;
        tick();
        burst_load = 1'b0;
        adv_n      = 1'b0;
        tick();
        check("R7 pre-reset advance", 2'b10, 2'd1);
        rst = 1'b1;
        tick();
        check("R1 mid-burst reset", 2'b00, 2'd0);
        rst   = 1'b0;
        adv_n = 1'b1;
        tick();

        // R2: back-to-back loads with a new start each cycle
        burst_load = 1'b1;
        order_sel  = 1'b0;
        start_lo   = 2'd2;
        tick();
        check("R2 first of back-to-back", 2'b10, 2'd0);
        start_lo = 2'd1;
        tick();
        check("R2 second of back-to-back", 2'b01, 2'd0);
        burst_load = 1'b0;
        adv_n      = 1'b0;
        tick();
        check("R6 linear step after reload", 2'b10, 2'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule